// File: doc/BRIEF.md
# Burst-Read FIFO Target for a Local Bus

This block answers local-bus transfers on the local side of a PCI target bridge. A sample FIFO is placed behind an address window of 36 KB. Every word address in that window selects the same FIFO. A burst therefore moves through the window one word per local clock, and each completed beat takes the next sample from the FIFO. The block is intended for bulk transfer of acquired samples, and it runs at local clocks up to 40 MHz.

A transfer starts with a one-cycle address strobe. Data beats follow from the next cycle onward, one beat per clock, and `lb_ready` is asserted for each of them. The master marks its last beat with `lb_blast`. The block ends a burst early through `lb_bterm` in three cases:
- the FIFO is empty (an underrun),
- the access is a single-beat I/O access,
- the burst reaches the last word of the window.

Writes to the window are acknowledged and then dropped. Strobes at addresses outside the window are ignored.

Top module: `lbus_fifo_target`

## Requirements
- R1: After reset, and while no transfer is active, `lb_ready`, `lb_bterm`, `lb_underrun` and `fifo_pop` are all 0, and `lb_rdata` is 0.
- R2: When `lb_ads` is high and `lb_addr` lies outside [WIN_BASE, WIN_BASE+WIN_BYTES), the strobe is ignored: `lb_ready` stays 0 and no transfer starts.
- R3: A read strobe inside the window starts beats on the next clock. On each beat where the FIFO is not empty, `lb_ready` is 1, `fifo_pop` is 1, and `lb_rdata` equals `fifo_rdata` in that same cycle (the FIFO shows its head word without a request).
- R4: A beat that is sampled with `lb_blast` high is the last beat. `lb_ready` is 0 on the following clock unless a new strobe arrives.
- R5: A write transfer (`lb_wr`=1) gets `lb_ready` on every beat, never pops the FIFO, drives `lb_rdata` as 0, and ends on its `lb_blast` beat.
- R6: An I/O access (`lb_io`=1 with the strobe) completes after exactly one beat. That beat asserts `lb_bterm` if `lb_blast` is low.
- R7: A read beat with `fifo_empty` high is an underrun. It gives `lb_ready`=1, `lb_rdata`=0, `lb_underrun`=1, `lb_bterm`=1 and `fifo_pop`=0, and it ends the transfer.
- R8: A beat at the last word of the window (byte offset WIN_BYTES-4) ends the transfer. That beat asserts `lb_bterm` when `lb_blast` is low.
- R9: `fifo_pop` is high only on a read beat with `lb_ready` high and `fifo_empty` low.
- R10: `lb_bterm` is high only together with `lb_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lb_ads | input | 1 | Address strobe, high for one clock at transfer start |
| lb_blast | input | 1 | High on the master's last data beat |
| lb_wr | input | 1 | 1 = write transfer, 0 = read transfer |
| lb_io | input | 1 | 1 = single-beat I/O access |
| lb_addr | input | AW | Byte address, sampled with the strobe |
| fifo_empty | input | 1 | FIFO has no word available |
| fifo_rdata | input | DW | Head word of the FIFO |
| lb_rdata | output | DW | Read data, valid when `lb_ready` is high |
| lb_ready | output | 1 | Beat completes this clock |
| lb_bterm | output | 1 | Target ends the burst on this beat |
| lb_underrun | output | 1 | This beat read an empty FIFO |
| fifo_pop | output | 1 | Remove the head word from the FIFO |

## Verification
The embedded assertions check the cycle-level rules on every clock:
- a pop happens only on a ready read beat with data present;
- a terminate never appears without ready;
- an underrun always terminates and never pops;
- a write beat never pops;
- ready drops after a `lb_blast` beat or an I/O beat;
- an outside strobe yields no ready.

Some behaviour only the bench scenarios can show, because it depends on sequences of stimulus:
- the actual data order through a burst;
- where the window boundary cuts a burst;
- that dropped writes leave the FIFO contents intact;
- what happens to data in the cycles after a terminated burst.

The behavioural model in the bench compares all outputs on every clock for these scenarios.

// File: rtl/lbt_pkg.sv
package lbt_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BEAT = 1'b1
  } lbt_state_e;

  typedef struct packed {
    logic wr;
    logic io;
  } lbt_attr_t;

endpackage

// File: rtl/lbt_rst_sync.sv
module lbt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/lbt_win_decode.sv
module lbt_win_decode #(
  parameter int          AW        = 16,
  parameter int unsigned WIN_BASE  = 0,
  parameter int unsigned WIN_BYTES = 36864,
  parameter int          BYTE_SH   = 2,
  parameter int          IDX_W     = 14
) (
  input  logic [AW-1:0]    addr_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam logic [AW:0]   WIN_END = (AW+1)'(WIN_BASE + WIN_BYTES);
  localparam logic [AW-1:0] BASE_A  = AW'(WIN_BASE);

  logic [AW-1:0] offset;

  generate
    if (WIN_BASE == 0) begin : g_zero_base
      assign hit_o = {1'b0, addr_i} < WIN_END;
    end else begin : g_offset_base
      assign hit_o = (addr_i >= BASE_A) && ({1'b0, addr_i} < WIN_END);
    end
  endgenerate

  assign offset = addr_i - BASE_A;
  assign idx_o  = offset[BYTE_SH +: IDX_W];

endmodule

// File: rtl/lbt_beat_ctrl.sv
module lbt_beat_ctrl
  import lbt_pkg::*;
#(
  parameter int IDX_W = 14,
  parameter int WORDS = 9216
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ads_i,
  input  logic             blast_i,
  input  logic             wr_i,
  input  logic             io_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] start_idx_i,
  input  logic             fifo_empty_i,
  output logic             active_o,
  output logic             wr_q_o,
  output logic             io_q_o,
  output logic             underrun_o,
  output logic             bterm_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  lbt_state_e       st_q, st_d;
  lbt_attr_t        attr_q, attr_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             load_en, adv_en, end_beat, at_last;

  always_comb begin
    active_o   = (st_q == ST_BEAT);
    underrun_o = active_o & ~attr_q.wr & fifo_empty_i;
    at_last    = (idx_q == LAST_IDX);
    end_beat   = active_o & (blast_i | attr_q.io | underrun_o | at_last);
    bterm_o    = active_o & (underrun_o | (~blast_i & (attr_q.io | at_last)));
    load_en    = ~active_o & ads_i & hit_i;
    adv_en     = active_o & ~end_beat;
    st_d       = st_q;
    attr_d     = attr_q;
    idx_d      = idx_q;
    if (load_en) begin
      st_d      = ST_BEAT;
      attr_d.wr = wr_i;
      attr_d.io = io_i;
      idx_d     = start_idx_i;
    end else if (end_beat) begin
      st_d = ST_IDLE;
    end else if (adv_en) begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      attr_q <= '0;
      idx_q  <= '0;
    end else begin
      st_q <= st_d;
      if (load_en) begin
        attr_q <= attr_d;
      end
      if (load_en | adv_en) begin
        idx_q <= idx_d;
      end
    end
  end

  assign wr_q_o = attr_q.wr;
  assign io_q_o = attr_q.io;

  AST_BLAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && blast_i) |=> !active_o || $past(load_en)); // R4
  AST_IO_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && attr_q.io) |=> !active_o); // R6
  AST_UNDERRUN_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |-> bterm_o); // R7
  AST_LAST_WORD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && at_last) |=> !active_o); // R8

endmodule

// File: rtl/lbt_read_path.sv
module lbt_read_path #(
  parameter int DW = 32
) (
  input  logic          active_i,
  input  logic          wr_q_i,
  input  logic          fifo_empty_i,
  input  logic [DW-1:0] fifo_rdata_i,
  output logic          ready_o,
  output logic          pop_o,
  output logic [DW-1:0] rdata_o
);

  always_comb begin
    ready_o = active_i;
    pop_o   = active_i & ~wr_q_i & ~fifo_empty_i;
    rdata_o = pop_o ? fifo_rdata_i : '0;
  end

endmodule

// File: rtl/lbus_fifo_target.sv
module lbus_fifo_target #(
  parameter int          AW        = 16,
  parameter int          DW        = 32,
  parameter int unsigned WIN_BASE  = 0,
  parameter int unsigned WIN_BYTES = 36864
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lb_ads,
  input  logic          lb_blast,
  input  logic          lb_wr,
  input  logic          lb_io,
  input  logic [AW-1:0] lb_addr,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_rdata,
  output logic [DW-1:0] lb_rdata,
  output logic          lb_ready,
  output logic          lb_bterm,
  output logic          lb_underrun,
  output logic          fifo_pop
);

  localparam int BYTE_SH = $clog2(DW / 8);
  localparam int WORDS   = int'(WIN_BYTES) >> BYTE_SH;
  localparam int IDX_W   = $clog2(WORDS);

  logic             rst_n_s;
  logic             hit;
  logic [IDX_W-1:0] start_idx;
  logic             active, wr_q, io_q, underrun, bterm;

  lbt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  lbt_win_decode #(
    .AW(AW), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES),
    .BYTE_SH(BYTE_SH), .IDX_W(IDX_W)
  ) u_dec (
    .addr_i (lb_addr),
    .hit_o  (hit),
    .idx_o  (start_idx)
  );

  lbt_beat_ctrl #(.IDX_W(IDX_W), .WORDS(WORDS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .ads_i        (lb_ads),
    .blast_i      (lb_blast),
    .wr_i         (lb_wr),
    .io_i         (lb_io),
    .hit_i        (hit),
    .start_idx_i  (start_idx),
    .fifo_empty_i (fifo_empty),
    .active_o     (active),
    .wr_q_o       (wr_q),
    .io_q_o       (io_q),
    .underrun_o   (underrun),
    .bterm_o      (bterm)
  );

  lbt_read_path #(.DW(DW)) u_rd (
    .active_i     (active),
    .wr_q_i       (wr_q),
    .fifo_empty_i (fifo_empty),
    .fifo_rdata_i (fifo_rdata),
    .ready_o      (lb_ready),
    .pop_o        (fifo_pop),
    .rdata_o      (lb_rdata)
  );

  assign lb_bterm    = bterm;
  assign lb_underrun = underrun;

  AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!lb_ready && lb_ads && !hit) |=> !lb_ready); // R2
  AST_WRITE_NO_POP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (lb_ready && wr_q) |-> !fifo_pop && lb_rdata == '0); // R5
  AST_POP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n_s)
    fifo_pop |-> lb_ready && !fifo_empty && !wr_q); // R9
  AST_UNDERRUN_NO_POP: assert property (@(posedge clk) disable iff (!rst_n_s)
    lb_underrun |-> !fifo_pop && lb_rdata == '0); // R7
  AST_BTERM_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n_s)
    lb_bterm |-> lb_ready); // R10
  AST_IO_TERM: assert property (@(posedge clk) disable iff (!rst_n_s)
    (lb_ready && io_q && !lb_blast) |-> lb_bterm); // R6

endmodule

// File: tb/lbus_fifo_target_test.sv
module lbus_fifo_target_test;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int WIN_BYTES = 36864;
  localparam int WORDS = WIN_BYTES / 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lb_ads = 1'b0, lb_blast = 1'b0, lb_wr = 1'b0, lb_io = 1'b0;
  logic [AW-1:0] lb_addr = '0;
  logic          fifo_empty = 1'b1;
  logic [DW-1:0] fifo_rdata = '0;
  logic [DW-1:0] lb_rdata;
  logic          lb_ready, lb_bterm, lb_underrun, fifo_pop;

  int    total = 0, bad = 0, cyc = 0;
  bit    done = 0;
  string tag = "R1";

  logic [DW-1:0] fq[$];
  bit m_act = 0, m_wr = 0, m_io = 0;
  int m_idx = 0;

  lbus_fifo_target #(.AW(AW), .DW(DW), .WIN_BASE(0), .WIN_BYTES(WIN_BYTES)) uut (
    .clk(clk), .rst_n(rst_n), .lb_ads(lb_ads), .lb_blast(lb_blast), .lb_wr(lb_wr),
    .lb_io(lb_io), .lb_addr(lb_addr), .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
    .lb_rdata(lb_rdata), .lb_ready(lb_ready), .lb_bterm(lb_bterm),
    .lb_underrun(lb_underrun), .fifo_pop(fifo_pop)
  );

  always #5 clk = ~clk;

  task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic show_head();
    fifo_empty = (fq.size() == 0);
    fifo_rdata = (fq.size() == 0) ? 32'hDEAD_0000 : fq[0];
  endtask

  // Expected outputs from the behavioural model, compared away from the edge
  always @(negedge clk) begin
    bit e_under, e_pop, e_bterm, last;
    e_under = m_act && !m_wr && fifo_empty;
    e_pop   = m_act && !m_wr && !fifo_empty;
    last    = (m_idx == WORDS - 1);
    e_bterm = m_act && (e_under || (!lb_blast && (m_io || last)));
    chk("ready", {31'b0, lb_ready}, {31'b0, m_act});
    chk("R9 pop", {31'b0, fifo_pop}, {31'b0, e_pop});
    chk("R10 bterm", {31'b0, lb_bterm}, {31'b0, e_bterm});
    chk("underrun", {31'b0, lb_underrun}, {31'b0, e_under});
    chk("rdata", lb_rdata, e_pop ? fifo_rdata : '0);
  end

  // Model state and FIFO update at the edge
  always @(posedge clk) begin
    bit e_under, last;
    cyc++;
    e_under = m_act && !m_wr && fifo_empty;
    last    = (m_idx == WORDS - 1);
    if (!rst_n) begin
      m_act = 0;
    end else if (!m_act) begin
      if (lb_ads && int'(lb_addr) < WIN_BYTES) begin
        m_act = 1; m_wr = lb_wr; m_io = lb_io; m_idx = int'(lb_addr) / 4;
      end
    end else if (lb_blast || m_io || e_under || last) begin
      m_act = 0;
    end else begin
      m_idx++;
    end
    if (fifo_pop && fq.size() > 0) void'(fq.pop_front());
    show_head();
    if (cyc > 20000 && !done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(bit ads, bit blast, bit wr, bit io, int addr);
    lb_ads = ads; lb_blast = blast; lb_wr = wr; lb_io = io; lb_addr = AW'(addr);
    @(posedge clk); #2;
  endtask

  task automatic burst(int addr, bit wr, bit io, int beats);
    step(1, 0, wr, io, addr);
    for (int i = 0; i < beats; i++) step(0, i == beats - 1, 0, 0, addr + 4 * (i + 1));
    step(0, 0, 0, 0, 0);
  endtask

  task automatic fill(int n, int seed);
    for (int i = 0; i < n; i++) fq.push_back(DW'(seed + i * 32'h0101_0101));
    show_head();
  endtask

  initial begin
    int keep;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) step(0, 0, 0, 0, 0);
    tag = "R1"; chk("R1 idle ready", {31'b0, lb_ready}, 32'd0);

    tag = "R2";
    step(1, 0, 0, 0, WIN_BYTES);
    step(1, 0, 0, 0, 16'hFFFC);
    repeat (2) step(0, 0, 0, 0, 0);

    tag = "R3"; fill(8, 32'h1000_0000);
    burst(16'h0100, 0, 0, 4);
    tag = "R4"; chk("R4 four pops", 32'(fq.size()), 32'd4);

    tag = "R5"; keep = fq.size();
    burst(16'h0200, 1, 0, 3);
    chk("R5 fifo untouched", 32'(fq.size()), 32'(keep));

    tag = "R6";
    step(1, 0, 0, 1, 16'h0040);
    repeat (3) step(0, 0, 0, 0, 0);
    chk("R6 one pop", 32'(fq.size()), 32'(keep - 1));

    tag = "R7"; fq.delete(); fill(2, 32'h2000_0000);
    step(1, 0, 0, 0, 16'h0300);
    repeat (5) step(0, 0, 0, 0, 0);
    chk("R7 drained", 32'(fq.size()), 32'd0);

    tag = "R8"; fill(6, 32'h3000_0000);
    step(1, 0, 0, 0, WIN_BYTES - 8);
    repeat (4) step(0, 0, 0, 0, 0);
    chk("R8 two pops", 32'(fq.size()), 32'd4);

    tag = "R3"; burst(16'h8FF0, 0, 0, 2);
    repeat (3) step(0, 0, 0, 0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule